// File: doc/BRIEF.md
# Cascadable Presettable Binary Counter Stage

This block is one stage of a synchronous binary up-counter, four bits wide by default, with a parallel preset. On every rising clock edge it does one of three things: it takes in a parallel word, it steps up by one, or it keeps its value. An active-low clear that does not wait for the clock forces the stage to zero at once. Two count enables are provided. Both must be high for the stage to count. Only the second one, the chain enable, also qualifies the terminal-count carry output.

Because of this split, stages can be joined into a wider counter with no glue logic. Each stage's carry output drives the chain enable of the stage above it. The count enable of every stage is tied to one common count-enable net, and all stages share one clock. The stage itself treats clear as a true asynchronous reset. Synchronising the release of clear to the clock is left to a reset synchroniser at the integration level.

Internally, a decoder picks one step per cycle from three named steps: STEP_PRESET, STEP_COUNT and STEP_HOLD. The value register then applies that step. The transitions are as follows. The value goes from any value to the data word when load is low (preset). It goes from v to v+1, wrapping from all-ones to zero, when load is high and both enables are high (count). It goes from v to v when load is high and either enable is low (hold). It goes from any value to zero at once while clear is low.

Top module: `preset_count_stage`

## Requirements
- R1: While clr_n is low, q is 0 immediately, with no clock edge needed, whatever the other inputs are.
- R2: With clr_n high and load_n low, the rising edge of clk loads q from din, whatever cnt_en and chain_en are.
- R3: With clr_n and load_n high and both cnt_en and chain_en high, a rising edge sets q to q+1 modulo 16, so 15 steps to 0.
- R4: With clr_n and load_n high and either cnt_en or chain_en low, a rising edge leaves q unchanged.
- R5: carry_out is high exactly when chain_en is high and q is 15 (all ones). It follows its inputs combinationally and does not depend on cnt_en.
- R6: Bit i of din loads bit i of q, so din[0] sets the least significant bit q[0].
- R7: Clear overrides load and count: rising edges that occur while clr_n is low leave q at 0.
- R8: When stages are chained (each carry_out to the next chain_en, all cnt_en common, one clock), they count as one wider binary counter. When the common enable is low, the chained counter holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Active-low asynchronous clear |
| load_n | input | 1 | Active-low synchronous parallel load |
| din | input | WIDTH | Parallel preset word, bit 0 is the LSB |
| cnt_en | input | 1 | Count enable, does not affect the carry |
| chain_en | input | 1 | Count enable that also qualifies the carry |
| q | output | WIDTH | Counter value |
| carry_out | output | 1 | Terminal-count carry for the next stage |

## Verification
The bench sweeps every start value against every control combination and every data word. This exposes a load that waits for the enables, a count gated by only one enable, and a 15-to-0 wrap that fails or saturates. It checks carry_out with cnt_en low to catch a carry that wrongly includes both enables. It pulls clear low between clock edges and then clocks with load active. A clear that waited for the clock, or that lost to load, would show a nonzero value. A three-stage chain is counted through the 0xFFF to 0x000 boundary and held with the common enable low. A carry taken from the wrong stage or not qualified by chain_en would make the upper stages step at the wrong time.

// File: rtl/pcs_pkg.sv
package pcs_pkg;

    // One step chosen per clock edge; clear is handled asynchronously.
    typedef enum logic [1:0] {
        STEP_HOLD   = 2'd0,
        STEP_COUNT  = 2'd1,
        STEP_PRESET = 2'd2
    } step_e;

endpackage

// File: rtl/pcs_step_decode.sv
module pcs_step_decode
    import pcs_pkg::*;
(
    input  logic  load_n,
    input  logic  cnt_en,
    input  logic  chain_en,
    output step_e step
);

    logic [1:0] sel;

    always_comb begin
        sel = {load_n, cnt_en & chain_en};
        unique case (sel)
            2'b00, 2'b01: step = STEP_PRESET;
            2'b11:        step = STEP_COUNT;
            2'b10:        step = STEP_HOLD;
            default:      step = STEP_HOLD;
        endcase
    end

endmodule

// File: rtl/pcs_value_reg.sv
module pcs_value_reg
    import pcs_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             clr_n,
    input  step_e            step,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] q
);

    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    logic [WIDTH-1:0] q_next;

    always_comb begin
        unique case (step)
            STEP_PRESET: q_next = din;
            STEP_COUNT:  q_next = q + ONE;
            STEP_HOLD:   q_next = q;
            default:     q_next = q;
        endcase
    end

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            q <= '0;
        end else begin
            q <= q_next;
        end
    end

endmodule

// File: rtl/pcs_terminal.sv
module pcs_terminal #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] q,
    input  logic             chain_en,
    output logic             carry_out
);

    logic [WIDTH-1:0] ones_acc;

    // Reduction built as an explicit AND chain over the bits.
    generate
        for (genvar b = 0; b < WIDTH; b++) begin : g_and
            if (b == 0) begin : g_first
                assign ones_acc[b] = q[b];
            end else begin : g_rest
                assign ones_acc[b] = ones_acc[b-1] & q[b];
            end
        end
    endgenerate

    assign carry_out = chain_en & ones_acc[WIDTH-1];

endmodule

// File: rtl/preset_count_stage.sv
module preset_count_stage
    import pcs_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic             load_n,
    input  logic [WIDTH-1:0] din,
    input  logic             cnt_en,
    input  logic             chain_en,
    output logic [WIDTH-1:0] q,
    output logic             carry_out
);

    step_e step;

    pcs_step_decode u_decode (
        .load_n   (load_n),
        .cnt_en   (cnt_en),
        .chain_en (chain_en),
        .step     (step)
    );

    pcs_value_reg #(.WIDTH(WIDTH)) u_value (
        .clk   (clk),
        .clr_n (clr_n),
        .step  (step),
        .din   (din),
        .q     (q)
    );

    pcs_terminal #(.WIDTH(WIDTH)) u_term (
        .q         (q),
        .chain_en  (chain_en),
        .carry_out (carry_out)
    );

endmodule

// File: rtl/pcs_checker.sv
module pcs_checker #(
    parameter int WIDTH = 4
) (
    input logic             clk,
    input logic             clr_n,
    input logic             load_n,
    input logic [WIDTH-1:0] din,
    input logic             cnt_en,
    input logic             chain_en,
    input logic [WIDTH-1:0] q,
    input logic             carry_out
);

    // R1
    clear_zero_chk: assert property (@(posedge clk) disable iff (clr_n)
        q == '0);

    // R2
    preset_take_chk: assert property (@(posedge clk) disable iff (!clr_n)
        !load_n |=> q == $past(din));

    // R3
    count_step_chk: assert property (@(posedge clk) disable iff (!clr_n)
        (load_n && cnt_en && chain_en) |=> q == WIDTH'($past(q) + 1'b1));

    // R4
    hold_value_chk: assert property (@(posedge clk) disable iff (!clr_n)
        (load_n && !(cnt_en && chain_en)) |=> $stable(q));

    // R5
    carry_term_chk: assert property (@(posedge clk) disable iff (!clr_n)
        carry_out == (chain_en && (q == {WIDTH{1'b1}})));

endmodule

bind preset_count_stage pcs_checker #(.WIDTH(WIDTH)) u_chk (
    .clk       (clk),
    .clr_n     (clr_n),
    .load_n    (load_n),
    .din       (din),
    .cnt_en    (cnt_en),
    .chain_en  (chain_en),
    .q         (q),
    .carry_out (carry_out)
);

// File: tb/test_preset_count_stage.sv
module test_preset_count_stage;

    localparam int W = 4;
    localparam int STAGES = 3;
    localparam int CW = W * STAGES;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    // Single stage under test
    logic         clr_n = 1'b0, load_n = 1'b1, cnt_en = 1'b0, chain_en = 1'b0;
    logic [W-1:0] din = '0;
    logic [W-1:0] q;
    logic         carry_out;

    preset_count_stage #(.WIDTH(W)) i_preset_count_stage (
        .clk(clk), .clr_n(clr_n), .load_n(load_n), .din(din),
        .cnt_en(cnt_en), .chain_en(chain_en), .q(q), .carry_out(carry_out)
    );

    // Chained stages
    logic          c_clr_n = 1'b0, c_load_n = 1'b1, c_en = 1'b0;
    logic [CW-1:0] c_din = '0;
    logic [CW-1:0] c_q;
    logic [STAGES-1:0] c_cy;

    for (genvar k = 0; k < STAGES; k++) begin : g_chain
        logic link;
        if (k == 0) begin : g_base
            assign link = c_en;
        end else begin : g_up
            assign link = c_cy[k-1];
        end
        preset_count_stage #(.WIDTH(W)) i_stage (
            .clk(clk), .clr_n(c_clr_n), .load_n(c_load_n),
            .din(c_din[k*W +: W]), .cnt_en(c_en), .chain_en(link),
            .q(c_q[k*W +: W]), .carry_out(c_cy[k])
        );
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // Drive after a falling edge, sample 1 ns after the next rising edge.
    task automatic edge_step();
        @(posedge clk);
        #1;
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        #1;
        // R1: reset state
        chk("R1 reset", int'(q), 0);
        chk("R5 reset carry", int'(carry_out), 0);
        @(negedge clk);
        clr_n = 1'b1;

        // R2 R3 R4 R5 R6: exhaustive sweep of start value, controls, data
        for (int s = 0; s < 16; s++) begin
            for (int ctl = 0; ctl < 8; ctl++) begin
                for (int d = 0; d < 16; d++) begin
                    @(negedge clk);
                    load_n = 1'b0; din = W'(s); cnt_en = 1'b0; chain_en = 1'b0;
                    edge_step();
                    @(negedge clk);
                    load_n   = ctl[2];
                    cnt_en   = ctl[1];
                    chain_en = ctl[0];
                    din      = W'(d);
                    #1;
                    // R5: carry independent of cnt_en
                    chk("R5 carry", int'(carry_out), (ctl[0] && s == 15) ? 1 : 0);
                    edge_step();
                    if (!ctl[2])
                        chk("R2 R6 preset", int'(q), d);
                    else if (ctl[1] && ctl[0])
                        chk("R3 count", int'(q), (s + 1) % 16);
                    else
                        chk("R4 hold", int'(q), s);
                end
            end
        end

        // R6: single-bit loads land on the matching output bit
        for (int b = 0; b < W; b++) begin
            @(negedge clk);
            load_n = 1'b0; din = W'(1 << b);
            edge_step();
            chk("R6 bit order", int'(q), 1 << b);
        end

        // R1: clear between edges, R7: clear beats load and count
        @(negedge clk);
        load_n = 1'b0; din = 4'd9;
        edge_step();
        chk("R2 before clear", int'(q), 9);
        #0.5;
        clr_n = 1'b0;
        #0.5;
        chk("R1 async clear", int'(q), 0);
        @(negedge clk);
        load_n = 1'b0; din = 4'd6; cnt_en = 1'b1; chain_en = 1'b1;
        edge_step();
        chk("R7 clear over load", int'(q), 0);
        @(negedge clk);
        load_n = 1'b1;
        edge_step();
        chk("R7 clear over count", int'(q), 0);
        chk("R5 carry at zero", int'(carry_out), 0);
        @(negedge clk);
        clr_n = 1'b1;
        edge_step();
        chk("R3 count after release", int'(q), 1);

        // R8: chained counter
        @(negedge clk);
        c_clr_n = 1'b1; c_en = 1'b1;
        for (int i = 1; i <= 300; i++) begin
            edge_step();
            chk("R8 chain count", int'(c_q), i);
        end
        @(negedge clk);
        c_load_n = 1'b0; c_din = 12'hFFD;
        edge_step();
        chk("R8 chain preset", int'(c_q), 12'hFFD);
        @(negedge clk);
        c_load_n = 1'b0; c_din = 12'hFFD; c_load_n = 1'b1;
        for (int i = 1; i <= 4; i++) begin
            edge_step();
            chk("R8 chain wrap", int'(c_q), (12'hFFD + i) % 4096);
            if (i == 2) chk("R8 top carry", int'(c_cy[STAGES-1]), 1);
            if (i == 3) chk("R8 top carry clear", int'(c_cy[STAGES-1]), 0);
        end
        @(negedge clk);
        c_load_n = 1'b0; c_din = 12'h0EF;
        edge_step();
        @(negedge clk);
        c_load_n = 1'b1; c_en = 1'b0;
        for (int i = 0; i < 5; i++) begin
            edge_step();
            chk("R8 chain hold", int'(c_q), 12'h0EF);
        end
        chk("R5 carry gated", int'(c_cy[0]), 0);
        @(negedge clk);
        c_en = 1'b1;
        edge_step();
        chk("R8 ripple into middle", int'(c_q), 12'h0F0);

        finish_run();
    end

endmodule